// File: doc/BRIEF.md
# BCD Calendar Clock with 12/24-Hour Mode

This block keeps wall-clock time and calendar date in eight byte-wide registers, all in binary-coded decimal. One pulse on `tick` stands for one hundredth of a second. Each pulse moves the hundredths counter forward, and a rollover there can ripple up through seconds, minutes, hours, day of week, date, month and year. The length of each month is respected, and February gets a 29th day in leap years.

Software or a host state machine sets the time through a one-cycle write port. The whole state can be read at any time through a combinational read port. Bit 7 of the hours register selects the hour format: 1 is 12-hour with an AM/PM flag, 0 is 24-hour. One bit in the day register stops and restarts counting. Bits that carry no meaning always read as zero.

Top module: `bcd_calendar_clock`

## Requirements
- R1: The registers sit at fixed addresses: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. After reset they read 00, 00, 00, 00, 01, 01, 01, 00 (hex), which is 24-hour mode with the clock running.
- R2: Each `tick` high cycle while running advances hundredths in BCD. Hundredths wrap 99→00 and carry into seconds, seconds wrap 59→00 into minutes, and minutes wrap 59→00 into hours. Cycles with `tick` low change nothing.
- R3: With hours bit 7 = 0, hours count 00 to 23 in BCD, using bit 5 as the tens-of-hours bit for 20–23. A carry into 23 gives 00 and advances the day.
- R4: With hours bit 7 = 1, bits 4:0 hold 12, 01 … 11 in BCD and bit 5 is the PM flag (1 = PM). 12 goes to 01 with the flag unchanged. 11 goes to 12 and inverts the flag. Only 11 PM → 12 AM advances the day.
- R5: Day bits 2:0 hold the day of week 1–7. Each day advance adds one, and 7 wraps to 1.
- R6: A day advance increments the date. It wraps to 01 and advances the month after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11.
- R7: February ends on 29 when the BCD year, read as a number 0–99, is divisible by 4 (year 00 included), and on 28 otherwise.
- R8: Month 12 wraps to 01 and advances the year. Year wraps 99→00.
- R9: Day bit 5 = 1 halts all counting, so ticks are ignored and every register holds. Writing it back to 0 resumes counting. The bit reads back as written.
- R10: Bits that carry no meaning always read 0, whatever was written. These are seconds bit 7, minutes bit 7, hours bit 6, day bits 7:6 and 4:3, date bits 7:6, and month bits 7:5. Hundredths and year keep all 8 bits.
- R11: A write that coincides with a running tick sets the addressed register to the written value and overrides its increment or carry. The other registers still advance for that tick, based on the values held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per hundredth of a second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address for the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register address for the read |
| rd_data | output | 8 | Combinational read data (unused bits zero) |

## Verification
The rarest events are the deep carries, such as a new year, the last day of February, or an 11 PM to midnight rollover in 12-hour mode. From reset, reaching them would take billions of ticks. The bench therefore writes every register to the instant just before the rollover, so that a single tick sends the carry through the whole chain. It sweeps every hour in both modes, every month across leap and common years, and every weekday this way. A separate case puts a write and a carry into the same cycle to exercise the priority rule.

// File: rtl/bcd_cal_pkg.sv
`timescale 1ns/1ps
package bcd_cal_pkg;
  localparam int REG_W  = 8;
  localparam int NREGS  = 8;
  localparam int ADDR_W = $clog2(NREGS);
  localparam int NWRAP  = 4;

  typedef logic [REG_W-1:0] byte_t;

  // Simple wrapping counters: hundredths, seconds, minutes, year
  localparam byte_t WRAP_LIM [NWRAP] = '{8'h99, 8'h59, 8'h59, 8'h99};
  localparam byte_t WRAP_MSK [NWRAP] = '{8'hFF, 8'h7F, 8'h7F, 8'hFF};
  localparam int    WRAP_IDX [NWRAP] = '{0, 1, 2, 7};

  localparam byte_t HOUR_MSK  = 8'hBF;
  localparam byte_t DAY_MSK   = 8'h27;
  localparam byte_t DATE_MSK  = 8'h3F;
  localparam byte_t MONTH_MSK = 8'h1F;
  localparam int    HALT_BIT  = 5;

  typedef struct packed {
    logic  carry;
    byte_t val;
  } hour_step_t;

  function automatic byte_t bcd_inc(input byte_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Divisible by 4: even tens need units 0/4/8, odd tens need units 2/6
  function automatic logic leap_year(input byte_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic byte_t month_last(input byte_t m, input byte_t y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic hour_step_t hour_next(input byte_t h);
    hour_step_t r;
    byte_t      t;
    r.carry = 1'b0;
    r.val   = h & HOUR_MSK;
    if (h[7]) begin
      if (h[4:0] == 5'h12) begin
        r.val = {h[7], 1'b0, h[5], 5'h01};
      end else if (h[4:0] == 5'h11) begin
        r.val   = {h[7], 1'b0, ~h[5], 5'h12};
        r.carry = h[5];
      end else begin
        t     = bcd_inc({3'b000, h[4:0]});
        r.val = {h[7], 1'b0, h[5], t[4:0]};
      end
    end else begin
      if (h[5:0] == 6'h23) begin
        r.val   = 8'h00;
        r.carry = 1'b1;
      end else begin
        t     = bcd_inc({2'b00, h[5:0]});
        r.val = {2'b00, t[5:0]};
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/bcd_wrap_counter.sv
`timescale 1ns/1ps
module bcd_wrap_counter
  import bcd_cal_pkg::*;
#(
  parameter byte_t LIMIT = 8'h99,
  parameter byte_t MASK  = 8'hFF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  wr,
  input  byte_t wr_val,
  output byte_t value,
  output logic  carry
);
  byte_t q;

  assign carry = step && (q == LIMIT);
  assign value = q;

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (wr)     q <= wr_val & MASK;
    else if (carry)  q <= '0;
    else if (step)   q <= bcd_inc(q);
  end
endmodule

// File: rtl/bcd_hour_counter.sv
`timescale 1ns/1ps
module bcd_hour_counter
  import bcd_cal_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  wr,
  input  byte_t wr_val,
  output byte_t value,
  output logic  day_carry
);
  byte_t      q;
  hour_step_t nxt;

  assign nxt       = hour_next(q);
  assign day_carry = step && nxt.carry;
  assign value     = q;

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr)    q <= wr_val & HOUR_MSK;
    else if (step)  q <= nxt.val;
  end
endmodule

// File: rtl/bcd_date_counter.sv
`timescale 1ns/1ps
module bcd_date_counter
  import bcd_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [2:0] wr,       // [0] day, [1] date, [2] month
  input  byte_t      wr_val,
  input  byte_t      year,
  output byte_t      day,
  output byte_t      date,
  output byte_t      month,
  output logic       halt,
  output logic       month_step,
  output logic       year_carry
);
  byte_t day_q, date_q, month_q;
  byte_t last_date;
  logic  dow_wrap;

  assign last_date  = month_last(month_q, year);
  assign dow_wrap   = (day_q[2:0] == 3'd7);
  assign month_step = step && (date_q == last_date);
  assign year_carry = month_step && (month_q == 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      day_q   <= 8'h01;
      date_q  <= 8'h01;
      month_q <= 8'h01;
    end else begin
      if (wr[0])     day_q <= wr_val & DAY_MSK;
      else if (step) day_q <= {day_q[7:3], dow_wrap ? 3'd1 : day_q[2:0] + 3'd1};

      if (wr[1])            date_q <= wr_val & DATE_MSK;
      else if (month_step)  date_q <= 8'h01;
      else if (step)        date_q <= bcd_inc(date_q);

      if (wr[2])            month_q <= wr_val & MONTH_MSK;
      else if (year_carry)  month_q <= 8'h01;
      else if (month_step)  month_q <= bcd_inc(month_q);
    end
  end

  assign day   = day_q;
  assign date  = date_q;
  assign month = month_q;
  assign halt  = day_q[HALT_BIT];
endmodule

// File: rtl/bcd_calendar_clock.sv
`timescale 1ns/1ps
module bcd_calendar_clock
  import bcd_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data
);
  logic [NREGS-1:0] wr_sel;
  logic             halt;
  logic             run_tick;
  logic             day_step;
  logic             month_step;
  logic             year_step;

  byte_t wc_val   [NWRAP];
  logic  wc_carry [NWRAP];
  logic  wc_step  [NWRAP];

  byte_t hund_q, sec_q, min_q, hour_q, day_q, date_q, month_q, year_q;

  always_comb begin
    wr_sel = '0;
    if (wr_en) wr_sel[wr_addr] = 1'b1;
  end

  assign run_tick = tick && !halt;

  // Step sources: chain for first three, month rollover for year
  assign wc_step[0] = run_tick;
  assign wc_step[1] = wc_carry[0];
  assign wc_step[2] = wc_carry[1];
  assign wc_step[3] = year_step;

  generate
    for (genvar i = 0; i < NWRAP; i++) begin : g_wrap
      bcd_wrap_counter #(
        .LIMIT (WRAP_LIM[i]),
        .MASK  (WRAP_MSK[i])
      ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (wc_step[i]),
        .wr     (wr_sel[WRAP_IDX[i]]),
        .wr_val (wr_data),
        .value  (wc_val[i]),
        .carry  (wc_carry[i])
      );
    end
  endgenerate

  assign hund_q = wc_val[0];
  assign sec_q  = wc_val[1];
  assign min_q  = wc_val[2];
  assign year_q = wc_val[3];

  bcd_hour_counter u_hour (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (wc_carry[2]),
    .wr        (wr_sel[3]),
    .wr_val    (wr_data),
    .value     (hour_q),
    .day_carry (day_step)
  );

  bcd_date_counter u_date (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (day_step),
    .wr         (wr_sel[6:4]),
    .wr_val     (wr_data),
    .year       (year_q),
    .day        (day_q),
    .date       (date_q),
    .month      (month_q),
    .halt       (halt),
    .month_step (month_step),
    .year_carry (year_step)
  );

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = hund_q;
      3'd1:    rd_data = sec_q;
      3'd2:    rd_data = min_q;
      3'd3:    rd_data = hour_q;
      3'd4:    rd_data = day_q;
      3'd5:    rd_data = date_q;
      3'd6:    rd_data = month_q;
      default: rd_data = year_q;
    endcase
  end
endmodule

// File: rtl/bcd_calendar_clock_checker.sv
`timescale 1ns/1ps
module bcd_calendar_clock_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       halt,
  input logic       wr_en,
  input logic [7:0] wr_sel,
  input logic [7:0] wr_data,
  input logic       sec_step,
  input logic       hour_step,
  input logic       day_step,
  input logic       month_step,
  input logic [7:0] hund_q,
  input logic [7:0] sec_q,
  input logic [7:0] hour_q,
  input logic [7:0] day_q,
  input logic [7:0] date_q,
  input logic [7:0] month_q
);
  // R2: a hundredths rollover always moves the seconds unless overwritten
  assert_sec_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && !wr_sel[1]) |=> !$stable(sec_q));

  // R2: hundredths at 99 with a running tick wraps to 00
  assert_hund_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !halt && hund_q == 8'h99 && !wr_sel[0]) |=> (hund_q == 8'h00));

  // R4: 11 -> 12 in 12-hour mode inverts the PM flag
  assert_pm_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_step && hour_q[7] && hour_q[4:0] == 5'h11 && !wr_sel[3])
      |=> (hour_q[5] != $past(hour_q[5])));

  // R6: a month advance restarts the date at 01
  assert_date_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (month_step && !wr_sel[5]) |=> (date_q == 8'h01));

  // R5: day of week never leaves 1..7 after a day advance
  assert_dow_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && !wr_sel[4]) |=> (day_q[2:0] != 3'd0));

  // R9: halted and not written, the time registers hold
  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_en) |=> ($stable(hund_q) && $stable(sec_q) && $stable(hour_q)));

  // R10: unused bits stay clear
  assert_zero_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[7] == 1'b0) && (hour_q[6] == 1'b0) && (day_q[7:6] == 2'b00) &&
    (day_q[4:3] == 2'b00) && (date_q[7:6] == 2'b00) && (month_q[7:5] == 3'b000));

  // R11: a write to seconds lands regardless of a carry that cycle
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[1] |=> (sec_q == ($past(wr_data) & 8'h7F)));
endmodule

bind bcd_calendar_clock bcd_calendar_clock_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .halt       (halt),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .sec_step   (wc_carry[0]),
  .hour_step  (wc_carry[2]),
  .day_step   (day_step),
  .month_step (month_step),
  .hund_q     (hund_q),
  .sec_q      (sec_q),
  .hour_q     (hour_q),
  .day_q      (day_q),
  .date_q     (date_q),
  .month_q    (month_q)
);

// File: tb/bcd_calendar_clock_bench.sv
`timescale 1ns/1ps
module bcd_calendar_clock_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bcd_calendar_clock u_bcd_calendar_clock (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] to_bcd(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string tag, input int addr, input logic [7:0] exp);
    rd_addr = 3'(addr);
    #0.5;
    n_checks++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s reg%0d actual=%h expected=%h", tag, addr, rd_data, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] hr, input logic [7:0] dy,
                         input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr);
    wr(0, 8'h99); wr(1, 8'h59); wr(2, 8'h59); wr(3, hr);
    wr(4, dy); wr(5, dt); wr(6, mo); wr(7, yr);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    begin
      logic [7:0] rv [8] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
      for (int a = 0; a < 8; a++) check("R1 reset", a, rv[a]);
    end

    // R2: 250 ticks from reset, hundredths and seconds arithmetic
    for (int n = 1; n <= 250; n++) begin
      pulse();
      check("R2 hundredths", 0, to_bcd(n % 100));
      check("R2 seconds", 1, to_bcd(n / 100));
    end
    // R2: idle cycles change nothing
    repeat (5) @(negedge clk);
    check("R2 idle", 0, to_bcd(50));

    // R2: second/minute carry into hour
    set_all(8'h05, 8'h01, 8'h01, 8'h01, 8'h00);
    pulse();
    check("R2 hund wrap", 0, 8'h00);
    check("R2 sec wrap", 1, 8'h00);
    check("R2 min wrap", 2, 8'h00);
    check("R2 hour carry", 3, 8'h06);

    // R3: every hour in 24-hour mode
    for (int h = 0; h < 24; h++) begin
      set_all(to_bcd(h), 8'h03, 8'h10, 8'h05, 8'h20);
      pulse();
      check("R3 hour24", 3, to_bcd((h + 1) % 24));
      check("R3 date", 5, (h == 23) ? 8'h11 : 8'h10);
      check("R5 dow via R3", 4, (h == 23) ? 8'h04 : 8'h03);
    end

    // R4: every hour in 12-hour mode, AM and PM
    for (int pm = 0; pm < 2; pm++) begin
      for (int h = 1; h <= 12; h++) begin
        int nh, npm;
        nh  = (h == 12) ? 1 : h + 1;
        npm = (h == 11) ? 1 - pm : pm;
        set_all(8'h80 | (pm ? 8'h20 : 8'h00) | to_bcd(h), 8'h02, 8'h07, 8'h03, 8'h21);
        pulse();
        check("R4 hour12", 3, 8'h80 | (npm ? 8'h20 : 8'h00) | to_bcd(nh));
        check("R4 day advance", 5, (h == 11 && pm == 1) ? 8'h08 : 8'h07);
      end
    end

    // R5: weekday wrap
    for (int d = 1; d <= 7; d++) begin
      set_all(8'h23, 8'(d), 8'h01, 8'h01, 8'h00);
      pulse();
      check("R5 weekday", 4, 8'((d == 7) ? 1 : d + 1));
    end

    // R6, R7, R8: month ends across years
    begin
      int years [6] = '{0, 1, 4, 10, 12, 99};
      for (int yi = 0; yi < 6; yi++) begin
        for (int m = 1; m <= 12; m++) begin
          int y, last;
          y = years[yi];
          last = days_in(m, y);
          set_all(8'h23, 8'h01, to_bcd(last - 1), to_bcd(m), to_bcd(y));
          pulse();
          check((m == 2) ? "R7 feb before end" : "R6 before end", 5, to_bcd(last));
          check("R6 month held", 6, to_bcd(m));
          set_all(8'h23, 8'h01, to_bcd(last), to_bcd(m), to_bcd(y));
          pulse();
          check((m == 2) ? "R7 feb rollover" : "R6 date rollover", 5, 8'h01);
          check("R6 month next", 6, to_bcd((m == 12) ? 1 : m + 1));
          check("R8 year", 7, to_bcd((m == 12) ? (y + 1) % 100 : y));
        end
      end
    end

    // R9: halt freezes counting, bit reads back, clearing resumes
    set_all(8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(0, 8'h42);
    wr(4, 8'h24);
    repeat (5) pulse();
    check("R9 halted hundredths", 0, 8'h42);
    check("R9 halt bit", 4, 8'h24);
    wr(4, 8'h04);
    pulse();
    check("R9 resumed", 0, 8'h43);

    // R10: unused bits read as zero
    begin
      logic [7:0] mk [8] = '{8'hFF, 8'h7F, 8'h7F, 8'hBF, 8'h27, 8'h3F, 8'h1F, 8'hFF};
      for (int a = 0; a < 8; a++) begin
        wr(a, 8'hFF);
        check("R10 masked", a, mk[a]);
      end
    end
    wr(4, 8'h01);

    // R11: write on a tick cycle wins for its register, others advance
    set_all(8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(0, 8'h42); wr(1, 8'h10);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h33;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R11 other advances", 0, 8'h43);
    check("R11 write wins", 1, 8'h33);
    wr(0, 8'h99);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h20;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R11 carry overridden", 1, 8'h20);
    check("R11 hundredths wrapped", 0, 8'h00);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h77;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R11 own increment overridden", 0, 8'h77);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule